// File: doc/BRIEF.md
# Instruction Field Decoder

This block parses a stream of instruction bytes, one per clock under a valid/ready handshake, and turns each instruction's addressing bytes into one decoded record. It walks through any legacy prefixes, an optional REX prefix in 64-bit mode, a single opcode byte, the MOD R/M byte, an optional SIB byte and an optional displacement. It then holds the record until the consumer accepts it.

The record reports several fields:
- the segment in use, and whether an override chose it
- the operand-size and address-size prefix flags
- the REX width bit
- the direction and width bits of the opcode
- the 4-bit register, index and base numbers
- the scale code and the sign-extended displacement

A mode input picks 16-bit, 32-bit or 64-bit addressing rules. Those rules decide whether a SIB byte and how many displacement bytes follow. A three-byte vector escape at the opcode position yields a record flagged as unsupported. Immediates, multi-byte opcode maps and execution are left to other blocks.

Top module: `insn_field_decoder`

## Requirements
- R1: After reset, and after a reset applied mid-instruction, in_ready is 1 and out_valid is 0, and the next record carries no prefix state from before the reset.
- R2: A byte is consumed only in a cycle with in_valid and in_ready both high. While out_valid is high, in_ready is 0 and every record output stays unchanged until a cycle with out_ready high. The cycle after that cycle, out_valid is 0 and in_ready is 1.
- R3: Segment prefix bytes set out_seg_ovr to 1 and out_seg to a code: 0x26→0 (ES), 0x2E→1 (CS), 0x36→2 (SS), 0x3E→3 (DS), 0x64→4 (FS), 0x65→5 (GS). When several appear, the last one wins. With none, out_seg is 3 (DS) and out_seg_ovr is 0.
- R4: Byte 0x66 sets out_opsz and byte 0x67 sets out_adsz. Bytes 0xF0, 0xF2 and 0xF3 are consumed without changing any record field. Addressing rules follow the mode input alone.
- R5: For the opcode byte, out_dir is its bit 1 (1: R/M operand into REG, as in 0x8B) and out_wide is its bit 0 (0 for 0x88, a byte move).
- R6: The MOD R/M byte splits as MOD = bits 7:6, REG = bits 5:3 and R/M = bits 2:0, reported on out_mod, out_reg[2:0] and out_base[2:0]. MOD=11 takes no SIB and no displacement.
- R7: In mode 0 (16-bit), no SIB byte is ever taken, so R/M=100 is SI. MOD=01 takes 1 displacement byte. MOD=10 takes 2. MOD=00 with R/M=110 takes 2. out_index and out_scale are 0.
- R8: In mode 1 (32-bit) or 2 (64-bit), R/M=100 with MOD other than 11 takes a SIB byte. Its scale sits in bits 7:6 (multiplier 1 << code), its index in bits 5:3 and its base in bits 2:0, reported on out_scale, out_index[2:0] and out_base[2:0]. With no SIB, out_index and out_scale are 0.
- R9: In modes 1 and 2, MOD=01 takes 1 displacement byte and MOD=10 takes 4. MOD=00 takes 4 when R/M=101, or when a SIB byte has base 101. Bytes arrive least significant first, and out_disp is sign-extended to 32 bits (0 when no displacement is taken).
- R10: In mode 2, a byte 0x40–0x4F directly before the opcode is REX. Bit 3 drives out_rexw, and bits 2, 1 and 0 become bit 3 of out_reg, out_index and out_base. In modes 0 and 1 such a byte is an opcode.
- R11: A REX byte followed by another prefix byte is discarded.
- R12: Opcode byte 0xC4 or 0x8F gives a record at once with out_unsup set, no SIB, MOD 0 and displacement 0, and consumes no further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Addressing rules: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit (3 acts as 32-bit) |
| in_valid | input | 1 | in_byte holds an instruction byte |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record is pending |
| out_ready | input | 1 | Consumer takes the record |
| out_seg | output | 3 | Segment code in use |
| out_seg_ovr | output | 1 | A segment override prefix was present |
| out_opsz | output | 1 | Operand-size prefix seen |
| out_adsz | output | 1 | Address-size prefix seen |
| out_rexw | output | 1 | REX width bit |
| out_dir | output | 1 | Opcode direction bit |
| out_wide | output | 1 | Opcode width bit |
| out_unsup | output | 1 | Vector escape met, record unsupported |
| out_has_sib | output | 1 | A SIB byte was taken |
| out_mod | output | 2 | MOD field |
| out_reg | output | 4 | Extended REG number |
| out_index | output | 4 | Extended SIB index number |
| out_base | output | 4 | Extended base (SIB base or R/M) number |
| out_scale | output | 2 | SIB scale code |
| out_disp | output | 32 | Sign-extended displacement |

## Verification
Every record field is registered, so out_valid and the complete record appear one clock after the handshake that takes the last byte of an instruction. That byte is the opcode for an escape, MOD R/M or SIB when no displacement follows, and the final displacement byte otherwise. The bench drives bytes on the falling edge and samples the record on the falling edge straight after that final handshake. It releases the record with out_ready and samples again one clock later, expecting out_valid low and in_ready high. Idle cycles are inserted between bytes of alternate vectors, so the timing is tied to the handshakes and not to a fixed count. In a directed case the record is held under back-pressure with a byte offered, and the bench confirms the outputs are stable and the byte was not taken.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int BYTE_W     = 8;
  localparam int DISP_W     = 32;
  localparam int DISP_BYTES = DISP_W / BYTE_W;
  localparam int CNT_W      = $clog2(DISP_BYTES + 1);
  localparam int RNUM_W     = 4;
  localparam int SEG_W      = 3;

  localparam logic [1:0] MODE16 = 2'd0;
  localparam logic [1:0] MODE64 = 2'd2;

  localparam logic [SEG_W-1:0] SEG_DEFAULT = 3'd3;

  typedef enum logic [2:0] {
    K_OPC, K_SEG, K_OPSZ, K_ADSZ, K_IGN, K_REX, K_ESC
  } byte_kind_e;

  typedef enum logic [2:0] {
    ST_PFX, ST_MODRM, ST_SIB, ST_DISP, ST_OUT
  } parse_state_e;
endpackage

// File: rtl/ifd_byte_class.sv
module ifd_byte_class
  import ifd_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              long_mode_i,
  output byte_kind_e        kind_o,
  output logic [SEG_W-1:0]  seg_o
);
  always_comb begin
    kind_o = K_OPC;
    seg_o  = '0;
    case (byte_i)
      8'h26: begin kind_o = K_SEG; seg_o = 3'd0; end
      8'h2E: begin kind_o = K_SEG; seg_o = 3'd1; end
      8'h36: begin kind_o = K_SEG; seg_o = 3'd2; end
      8'h3E: begin kind_o = K_SEG; seg_o = 3'd3; end
      8'h64: begin kind_o = K_SEG; seg_o = 3'd4; end
      8'h65: begin kind_o = K_SEG; seg_o = 3'd5; end
      8'h66: kind_o = K_OPSZ;
      8'h67: kind_o = K_ADSZ;
      8'hF0, 8'hF2, 8'hF3: kind_o = K_IGN;
      8'hC4, 8'h8F: kind_o = K_ESC;
      default: begin
        if (long_mode_i && byte_i[7:4] == 4'h4) kind_o = K_REX;
      end
    endcase
  end
endmodule

// File: rtl/ifd_addr_rules.sv
module ifd_addr_rules
  import ifd_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [BYTE_W-1:0] modrm_i,
  input  logic [2:0]        sib_base_i,
  output logic              need_sib_o,
  output logic [CNT_W-1:0]  disp_len_o
);
  logic       narrow;
  logic [1:0] md;
  logic [2:0] rm;

  always_comb begin
    narrow     = (mode_i == MODE16);
    md         = modrm_i[7:6];
    rm         = modrm_i[2:0];
    need_sib_o = !narrow && (md != 2'b11) && (rm == 3'b100);
    disp_len_o = '0;
    if (narrow) begin
      case (md)
        2'b01:   disp_len_o = CNT_W'(1);
        2'b10:   disp_len_o = CNT_W'(2);
        2'b00:   if (rm == 3'b110) disp_len_o = CNT_W'(2);
        default: disp_len_o = '0;
      endcase
    end else begin
      case (md)
        2'b01:   disp_len_o = CNT_W'(1);
        2'b10:   disp_len_o = CNT_W'(DISP_BYTES);
        2'b00: begin
          if (rm == 3'b101)
            disp_len_o = CNT_W'(DISP_BYTES);
          else if (rm == 3'b100 && sib_base_i == 3'b101)
            disp_len_o = CNT_W'(DISP_BYTES);
        end
        default: disp_len_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ifd_disp_acc.sv
module ifd_disp_acc
  import ifd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic [DISP_W-1:0] disp_o
);
  localparam int IDX_W = $clog2(DISP_W);

  wire [DISP_W-1:0] raw;

  for (genvar g = 0; g < DISP_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              lane_en;
    assign lane_en = wr_en_i && (wr_idx_i == CNT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (clr_i)   lane_q <= '0;
      else if (lane_en) lane_q <= wr_byte_i;
    end
    assign raw[g*BYTE_W +: BYTE_W] = lane_q;
  end

  int   sel;
  logic sgn;
  always_comb begin
    sel = int'(len_i) * BYTE_W;
    sgn = (sel == 0) ? 1'b0 : raw[IDX_W'(sel - 1)];
    for (int k = 0; k < DISP_W; k++) disp_o[k] = (k < sel) ? raw[k] : sgn;
  end

  assert_lane_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (int'(wr_idx_i) < DISP_BYTES) && (wr_idx_i < len_i));
endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
  import ifd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SEG_W-1:0]  out_seg,
  output logic              out_seg_ovr,
  output logic              out_opsz,
  output logic              out_adsz,
  output logic              out_rexw,
  output logic              out_dir,
  output logic              out_wide,
  output logic              out_unsup,
  output logic              out_has_sib,
  output logic [1:0]        out_mod,
  output logic [RNUM_W-1:0] out_reg,
  output logic [RNUM_W-1:0] out_index,
  output logic [RNUM_W-1:0] out_base,
  output logic [1:0]        out_scale,
  output logic [DISP_W-1:0] out_disp
);
  parse_state_e      state_q, state_d;
  logic [SEG_W-1:0]  seg_q, seg_d;
  logic              ovr_q, ovr_d, opsz_q, opsz_d, adsz_q, adsz_d;
  logic              rexv_q, rexv_d;
  logic [3:0]        rex_q, rex_d;
  logic              dir_q, dir_d, wide_q, wide_d, unsup_q, unsup_d;
  logic              sibv_q, sibv_d;
  logic [BYTE_W-1:0] modrm_q, modrm_d, sib_q, sib_d;
  logic [CNT_W-1:0]  dlen_q, dlen_d, dcnt_q, dcnt_d;

  logic              take, done;
  byte_kind_e        kind;
  logic [SEG_W-1:0]  cls_seg;
  logic [BYTE_W-1:0] rule_modrm;
  logic              need_sib;
  logic [CNT_W-1:0]  rule_len;

  assign in_ready  = (state_q != ST_OUT);
  assign out_valid = (state_q == ST_OUT);
  assign take      = in_valid && in_ready;
  assign done      = out_valid && out_ready;

  ifd_byte_class u_class (
    .byte_i      (in_byte),
    .long_mode_i (mode == MODE64),
    .kind_o      (kind),
    .seg_o       (cls_seg)
  );

  assign rule_modrm = (state_q == ST_SIB) ? modrm_q : in_byte;

  ifd_addr_rules u_rules (
    .mode_i     (mode),
    .modrm_i    (rule_modrm),
    .sib_base_i (in_byte[2:0]),
    .need_sib_o (need_sib),
    .disp_len_o (rule_len)
  );

  ifd_disp_acc u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (done),
    .wr_en_i   (take && state_q == ST_DISP),
    .wr_idx_i  (dcnt_q),
    .wr_byte_i (in_byte),
    .len_i     (dlen_q),
    .disp_o    (out_disp)
  );

  always_comb begin
    state_d = state_q;
    seg_d   = seg_q;   ovr_d  = ovr_q;  opsz_d = opsz_q; adsz_d = adsz_q;
    rexv_d  = rexv_q;  rex_d  = rex_q;
    dir_d   = dir_q;   wide_d = wide_q; unsup_d = unsup_q;
    sibv_d  = sibv_q;  modrm_d = modrm_q; sib_d = sib_q;
    dlen_d  = dlen_q;  dcnt_d = dcnt_q;
    case (state_q)
      ST_PFX: if (take) begin
        case (kind)
          K_SEG:  begin seg_d = cls_seg; ovr_d = 1'b1; rexv_d = 1'b0; end
          K_OPSZ: begin opsz_d = 1'b1; rexv_d = 1'b0; end
          K_ADSZ: begin adsz_d = 1'b1; rexv_d = 1'b0; end
          K_IGN:  rexv_d = 1'b0;
          K_REX:  begin rexv_d = 1'b1; rex_d = in_byte[3:0]; end
          K_ESC:  begin unsup_d = 1'b1; rexv_d = 1'b0; state_d = ST_OUT; end
          default: begin
            dir_d   = in_byte[1];
            wide_d  = in_byte[0];
            state_d = ST_MODRM;
          end
        endcase
      end
      ST_MODRM: if (take) begin
        modrm_d = in_byte;
        if (need_sib) begin
          sibv_d  = 1'b1;
          state_d = ST_SIB;
        end else begin
          dlen_d  = rule_len;
          state_d = (rule_len != '0) ? ST_DISP : ST_OUT;
        end
      end
      ST_SIB: if (take) begin
        sib_d   = in_byte;
        dlen_d  = rule_len;
        state_d = (rule_len != '0) ? ST_DISP : ST_OUT;
      end
      ST_DISP: if (take) begin
        dcnt_d = dcnt_q + CNT_W'(1);
        if (dcnt_q + CNT_W'(1) == dlen_q) state_d = ST_OUT;
      end
      default: if (done) begin
        state_d = ST_PFX;
        seg_d   = SEG_DEFAULT; ovr_d = 1'b0; opsz_d = 1'b0; adsz_d = 1'b0;
        rexv_d  = 1'b0; rex_d = '0;
        dir_d   = 1'b0; wide_d = 1'b0; unsup_d = 1'b0;
        sibv_d  = 1'b0; modrm_d = '0; sib_d = '0;
        dlen_d  = '0;   dcnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PFX;
      seg_q   <= SEG_DEFAULT; ovr_q <= 1'b0; opsz_q <= 1'b0; adsz_q <= 1'b0;
      rexv_q  <= 1'b0; rex_q <= '0;
      dir_q   <= 1'b0; wide_q <= 1'b0; unsup_q <= 1'b0;
      sibv_q  <= 1'b0; modrm_q <= '0; sib_q <= '0;
      dlen_q  <= '0;   dcnt_q <= '0;
    end else begin
      state_q <= state_d;
      seg_q   <= seg_d;  ovr_q  <= ovr_d;  opsz_q <= opsz_d; adsz_q <= adsz_d;
      rexv_q  <= rexv_d; rex_q  <= rex_d;
      dir_q   <= dir_d;  wide_q <= wide_d; unsup_q <= unsup_d;
      sibv_q  <= sibv_d; modrm_q <= modrm_d; sib_q <= sib_d;
      dlen_q  <= dlen_d; dcnt_q <= dcnt_d;
    end
  end

  logic rex_r, rex_x, rex_b;
  assign rex_r = rexv_q & rex_q[2];
  assign rex_x = rexv_q & rex_q[1];
  assign rex_b = rexv_q & rex_q[0];

  assign out_seg     = seg_q;
  assign out_seg_ovr = ovr_q;
  assign out_opsz    = opsz_q;
  assign out_adsz    = adsz_q;
  assign out_rexw    = rexv_q & rex_q[3];
  assign out_dir     = dir_q;
  assign out_wide    = wide_q;
  assign out_unsup   = unsup_q;
  assign out_has_sib = sibv_q;
  assign out_mod     = modrm_q[7:6];
  assign out_reg     = {rex_r, modrm_q[5:3]};
  assign out_index   = sibv_q ? {rex_x, sib_q[5:3]} : '0;
  assign out_base    = sibv_q ? {rex_b, sib_q[2:0]} : {rex_b, modrm_q[2:0]};
  assign out_scale   = sibv_q ? sib_q[7:6] : 2'b00;

  assert_record_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_disp) && $stable(out_reg)
      && $stable(out_base) && $stable(out_index) && $stable(out_seg));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  assert_no_sib_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_has_sib |-> out_index == '0 && out_scale == 2'b00);

  assert_escape_bare_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unsup |-> !out_has_sib && out_disp == '0 && out_mod == 2'b00);

  assert_narrow_no_sib_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode == MODE16 && $stable(mode) |-> !out_has_sib);
endmodule

// File: tb/insn_field_decoder_tb.sv
module insn_field_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_byte;
  logic [2:0]  out_seg;
  logic        out_seg_ovr, out_opsz, out_adsz, out_rexw, out_dir, out_wide;
  logic        out_unsup, out_has_sib;
  logic [1:0]  out_mod, out_scale;
  logic [3:0]  out_reg, out_index, out_base;
  logic [31:0] out_disp;

  always #2 clk = ~clk;

  insn_field_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_seg(out_seg), .out_seg_ovr(out_seg_ovr), .out_opsz(out_opsz),
    .out_adsz(out_adsz), .out_rexw(out_rexw), .out_dir(out_dir), .out_wide(out_wide),
    .out_unsup(out_unsup), .out_has_sib(out_has_sib), .out_mod(out_mod),
    .out_reg(out_reg), .out_index(out_index), .out_base(out_base),
    .out_scale(out_scale), .out_disp(out_disp)
  );

  typedef struct packed {
    logic [2:0]  seg;
    logic [7:0]  flags;   // ovr,opsz,adsz,rexw,dir,wide,unsup,sib
    logic [1:0]  mod;
    logic [3:0]  rg;
    logic [3:0]  ix;
    logic [3:0]  bs;
    logic [1:0]  sc;
    logic [31:0] disp;
  } rec_t;

  typedef struct packed {
    logic [1:0]  md;
    logic [3:0]  nb;
    logic [63:0] by;      // first byte in the top octet
    rec_t        ex;
  } vec_t;

  function automatic vec_t mk(int md, int nb, logic [63:0] by, int seg, logic [7:0] fl,
                              int mod, int rg, int ix, int bs, int sc, logic [31:0] d);
    vec_t v;
    v.md = 2'(md); v.nb = 4'(nb); v.by = by;
    v.ex.seg = 3'(seg); v.ex.flags = fl; v.ex.mod = 2'(mod); v.ex.rg = 4'(rg);
    v.ex.ix = 4'(ix); v.ex.bs = 4'(bs); v.ex.sc = 2'(sc); v.ex.disp = d;
    return v;
  endfunction

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    mk(1,2,64'h88D0_0000_0000_0000,3,8'b00000000,3,2,0,0,0,32'h0),
    mk(0,2,64'h89F2_0000_0000_0000,3,8'b00000100,3,6,0,2,0,32'h0),
    mk(0,2,64'h8B11_0000_0000_0000,3,8'b00001100,0,2,0,1,0,32'h0),
    mk(0,3,64'h8B56_3E00_0000_0000,3,8'b00001100,1,2,0,6,0,32'h3E),
    mk(0,3,64'h8B54_F300_0000_0000,3,8'b00001100,1,2,0,4,0,32'hFFFFFFF3),
    mk(0,4,64'h8B16_3412_0000_0000,3,8'b00001100,0,2,0,6,0,32'h1234),
    mk(0,4,64'h8994_0080_0000_0000,3,8'b00000100,2,2,0,4,0,32'hFFFF8000),
    mk(1,3,64'h8B04_4B00_0000_0000,3,8'b00001101,0,0,1,3,1,32'h0),
    mk(1,5,64'h268B_44CB_1000_0000,0,8'b10001101,1,0,1,3,3,32'h10),
    mk(1,6,64'h8B05_7856_3412_0000,3,8'b00001100,0,0,0,5,0,32'h12345678),
    mk(1,7,64'h8B04_25F0_FFFF_FF00,3,8'b00001101,0,0,4,5,0,32'hFFFFFFF0),
    mk(1,7,64'h8B84_8B00_0100_0000,3,8'b00001101,2,0,1,3,2,32'h100),
    mk(2,4,64'h488B_044B_0000_0000,3,8'b00011101,0,0,1,3,1,32'h0),
    mk(2,4,64'h498B_040B_0000_0000,3,8'b00011101,0,0,1,11,0,32'h0),
    mk(2,4,64'h4C8B_240B_0000_0000,3,8'b00011101,0,12,1,3,0,32'h0),
    mk(2,4,64'h428B_040B_0000_0000,3,8'b00001101,0,0,9,3,0,32'h0),
    mk(2,4,64'h482E_8BC1_0000_0000,1,8'b10001100,3,0,0,1,0,32'h0),
    mk(1,2,64'h48D0_0000_0000_0000,3,8'b00000000,3,2,0,0,0,32'h0),
    mk(1,5,64'h6667_F389_D000_0000,3,8'b01100100,3,2,0,0,0,32'h0),
    mk(1,5,64'h262E_658B_0000_0000,5,8'b10001100,0,0,0,0,0,32'h0),
    mk(2,1,64'hC400_0000_0000_0000,3,8'b00000010,0,0,0,0,0,32'h0),
    mk(1,2,64'hF28F_0000_0000_0000,3,8'b00000010,0,0,0,0,0,32'h0),
    mk(0,2,64'h8B04_0000_0000_0000,3,8'b00001100,0,0,0,4,0,32'h0),
    mk(2,3,64'h418B_C200_0000_0000,3,8'b00001100,3,0,0,10,0,32'h0),
    mk(1,3,64'h8B4D_FC00_0000_0000,3,8'b00001100,1,1,0,5,0,32'hFFFFFFFC),
    mk(2,5,64'h4F8B_7C24_0800_0000,3,8'b00011101,1,15,12,12,0,32'h8),
    mk(0,5,64'h3666_8B46_FE00_0000,2,8'b11001100,1,0,0,6,0,32'hFFFFFFFE),
    mk(1,5,64'h3E64_8A1C_2400_0000,4,8'b10001001,0,3,4,4,0,32'h0)
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:                  return "R5/R6";
      2, 3, 4, 5, 6, 22, 26: return "R7";
      7, 10, 11:             return "R8/R9";
      8, 19, 27:             return "R3";
      9, 24:                 return "R9";
      12, 13, 14, 15, 17, 23, 25: return "R10";
      16:                    return "R11";
      18:                    return "R4";
      default:               return "R12";
    endcase
  endfunction

  int n_chk = 0;
  int n_bad = 0;

  function automatic rec_t grab();
    rec_t r;
    r.seg = out_seg;
    r.flags = {out_seg_ovr, out_opsz, out_adsz, out_rexw, out_dir, out_wide,
               out_unsup, out_has_sib};
    r.mod = out_mod; r.rg = out_reg; r.ix = out_index; r.bs = out_base;
    r.sc = out_scale; r.disp = out_disp;
    return r;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic feed(logic [63:0] by, int nb, bit gaps);
    for (int b = 0; b < nb; b++) begin
      if (gaps && b > 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_byte  = by[63 - 8*b -: 8];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic release_rec(string req);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(req, "after release out_valid,in_ready", {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode = 2'd1; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "in reset out_valid,in_ready", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after reset out_valid,in_ready", {62'd0, out_valid, in_ready}, 64'd1);

    // table walk: R3..R12, with R2 release after every record
    for (int i = 0; i < NV; i++) begin
      mode = VECS[i].md;
      feed(VECS[i].by, int'(VECS[i].nb), i % 2 == 1);
      check(req_of(i), $sformatf("vec %0d out_valid", i), {63'd0, out_valid}, 64'd1);
      check(req_of(i), $sformatf("vec %0d record", i), 64'(grab()), 64'(VECS[i].ex));
      release_rec("R2");
    end

    // R2: record held under back-pressure, offered byte not taken
    begin
      rec_t held;
      mode = 2'd1;
      feed(64'h8B84_8B00_0100_0000, 7, 1'b0);
      held = grab();
      in_valid = 1'b1; in_byte = 8'h26;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        check("R2", "held valid,ready", {62'd0, out_valid, in_ready}, 64'd2);
        check("R2", "held record", 64'(grab()), 64'(held));
      end
      in_valid = 1'b0;
      release_rec("R2");
      feed(64'h88D0_0000_0000_0000, 2, 1'b0);
      check("R2", "stalled prefix not taken", 64'(grab()), 64'(VECS[0].ex));
      release_rec("R2");
    end

    // R1: reset in the middle of an instruction
    begin
      mode = 2'd1;
      feed(64'h2666_8B00_0000_0000, 3, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "mid reset out_valid,in_ready", {62'd0, out_valid, in_ready}, 64'd1);
      feed(64'h88D0_0000_0000_0000, 2, 1'b0);
      check("R1", "record after mid reset", 64'(grab()), 64'(VECS[0].ex));
      release_rec("R1");
    end

    finish_run();
  end
endmodule